// File: doc/BRIEF.md
# Next Fetch Address Sequencer with Branch Delay Slot

This block holds the program counter of a 32-bit processor that addresses bytes and keeps every instruction on a 4-byte boundary. Each cycle it receives the instruction word fetched at the current PC, together with three decoded controls: a jump flag, a conditional-branch flag and the already-evaluated branch outcome. From these it selects the address of the next fetch.

Three kinds of flow are supported. In sequential flow the PC steps by one word. An absolute jump keeps the region bits of the following instruction's address and replaces the remaining bits with the 26-bit instruction field followed by two zero bits. A taken conditional branch adds a sign-extended, word-scaled 16-bit offset to the address of the following instruction. The following instruction always executes as a delay slot, so the redirect is held for one cycle and the PC takes the target only after the delay-slot word has been fetched. The PC+4 value is also driven out for link-register writes.

Top module: `nextpc_seq`

## Requirements
- R1: A synchronous active-high reset loads the PC with the reset vector RESET_VEC (default 32'h20CE88C0) and drops any held redirect, so the first fetch after reset is RESET_VEC+4.
- R2: With no redirect held, the PC advances by 4 on every clock edge, and `pc_link` always equals `pc`+4.
- R3: When `is_jump` is 1, the target is {(`pc`+4)[31:28], `instr`[25:0], 2'b00}; it is a bit concatenation, so no carry ever reaches bits [31:28].
- R4: When `is_branch` and `br_taken` are both 1, the target is `pc`+4 plus `instr`[15:0] read as a two's complement word count, multiplied by 4; negative counts branch backward, and a count of -1 targets the branch itself.
- R5: On the edge after a jump or taken branch is decoded, the PC takes the delay-slot address (the decode PC plus 4) and `fetch_addr` shows the target; on the edge after that, the PC takes the target.
- R6: A branch with `br_taken` at 0 leaves flow sequential.
- R7: A jump or taken branch decoded in a delay slot is ignored: the held redirect still lands, and flow after it is sequential.
- R8: The two least significant bits of `pc` and of `fetch_addr` are always 0.
- R9: When `is_jump` and a taken branch are both asserted, the jump target is used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word fetched at `pc` |
| is_jump | input | 1 | Decoded absolute jump |
| is_branch | input | 1 | Decoded conditional branch |
| br_taken | input | 1 | Evaluated branch condition |
| pc | output | 32 | Address of the current instruction |
| pc_link | output | 32 | `pc` + 4, for link writes |
| fetch_addr | output | 32 | Address the PC takes at the next edge |

## Verification
`fetch_addr` is combinational. It follows the inputs of the current cycle in the same cycle, and the bench reads it one time unit after driving them. `pc` and `pc_link` change at the next rising edge, so they are read at the following falling edge. A redirect appears on `fetch_addr` in the cycle after decode and on `pc` one edge later. The bench's model advances by exactly one state per edge, so each comparison falls in the cycle its result is due.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
   // Flow kind selected at decode
   typedef enum logic [1:0] {
      FLOW_SEQ    = 2'd0,
      FLOW_JUMP   = 2'd1,
      FLOW_BRANCH = 2'd2
   } flow_e;
endpackage

// File: rtl/nextpc_jump_tgt.sv
module nextpc_jump_tgt #(
   parameter int ADDR_W   = 32,
   parameter int INSTR_W  = 32,
   parameter int JFIELD_W = 26,
   parameter int ALIGN_W  = 2
) (
   input  logic [ADDR_W-1:0]  link_addr,
   input  logic [INSTR_W-1:0] instr,
   output logic [ADDR_W-1:0]  target
);
   localparam int REGION_W = ADDR_W - JFIELD_W - ALIGN_W;

   generate
      if (REGION_W < 0) begin : g_bad_split
         $error("jump field and alignment exceed address width");
      end else if (REGION_W == 0) begin : g_no_region
         assign target = {instr[JFIELD_W-1:0], {ALIGN_W{1'b0}}};
      end else begin : g_region
         assign target = {link_addr[ADDR_W-1 -: REGION_W],
                          instr[JFIELD_W-1:0], {ALIGN_W{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/nextpc_branch_tgt.sv
module nextpc_branch_tgt #(
   parameter int ADDR_W  = 32,
   parameter int INSTR_W = 32,
   parameter int IMM_W   = 16,
   parameter int ALIGN_W = 2
) (
   input  logic [ADDR_W-1:0]  link_addr,
   input  logic [INSTR_W-1:0] instr,
   output logic [ADDR_W-1:0]  target
);
   localparam int EXT_W = ADDR_W - IMM_W - ALIGN_W;

   logic [ADDR_W-1:0] offset;

   generate
      if (EXT_W < 0) begin : g_bad_imm
         $error("branch immediate too wide for address");
      end else if (EXT_W == 0) begin : g_no_ext
         assign offset = {instr[IMM_W-1:0], {ALIGN_W{1'b0}}};
      end else begin : g_ext
         assign offset = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0],
                          {ALIGN_W{1'b0}}};
      end
   endgenerate

   assign target = link_addr + offset;
endmodule

// File: rtl/nextpc_redirect.sv
module nextpc_redirect #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_target,
   output logic              accept,
   output logic              held,
   output logic [ADDR_W-1:0] held_target
);
   // A request is only taken outside a delay slot
   assign accept = req & ~held;

   always_ff @(posedge clk) begin
      if (rst) begin
         held        <= 1'b0;
         held_target <= '0;
      end else begin
         held <= accept;
         if (accept) held_target <= req_target;
      end
   end

   assert_hold_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
      held |=> !held);
endmodule

// File: rtl/nextpc_seq.sv
module nextpc_seq
   import nextpc_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          INSTR_W   = 32,
   parameter int          JFIELD_W  = 26,
   parameter int          IMM_W     = 16,
   parameter int          ALIGN_W   = 2,
   parameter logic [31:0] RESET_VEC = 32'h20CE88C0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr,
   input  logic               is_jump,
   input  logic               is_branch,
   input  logic               br_taken,
   output logic [ADDR_W-1:0]  pc,
   output logic [ADDR_W-1:0]  pc_link,
   output logic [ADDR_W-1:0]  fetch_addr
);
   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(1) << ALIGN_W;
   localparam logic [ADDR_W-1:0] RVEC  = ADDR_W'(RESET_VEC);

   generate
      if (RESET_VEC[ALIGN_W-1:0] != '0) begin : g_bad_vec
         $error("reset vector not word aligned");
      end
      if (JFIELD_W >= INSTR_W || IMM_W >= INSTR_W) begin : g_bad_fields
         $error("instruction fields exceed instruction width");
      end
   endgenerate

   flow_e             flow;
   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] jump_target;
   logic [ADDR_W-1:0] branch_target;
   logic [ADDR_W-1:0] req_target;
   logic              req;
   logic              accept;
   logic              held;
   logic [ADDR_W-1:0] held_target;

   assign pc      = pc_q;
   assign pc_link = pc_q + STEP;

   // Jump has priority over a simultaneous taken branch
   always_comb begin
      if (is_jump)                    flow = FLOW_JUMP;
      else if (is_branch && br_taken) flow = FLOW_BRANCH;
      else                            flow = FLOW_SEQ;
   end

   nextpc_jump_tgt #(
      .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .JFIELD_W(JFIELD_W), .ALIGN_W(ALIGN_W)
   ) u_jump (
      .link_addr(pc_link), .instr(instr), .target(jump_target)
   );

   nextpc_branch_tgt #(
      .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .IMM_W(IMM_W), .ALIGN_W(ALIGN_W)
   ) u_branch (
      .link_addr(pc_link), .instr(instr), .target(branch_target)
   );

   always_comb begin
      unique case (flow)
         FLOW_JUMP:   req_target = jump_target;
         FLOW_BRANCH: req_target = branch_target;
         default:     req_target = pc_link;
      endcase
   end

   assign req = (flow != FLOW_SEQ);

   nextpc_redirect #(.ADDR_W(ADDR_W)) u_redirect (
      .clk(clk), .rst(rst), .req(req), .req_target(req_target),
      .accept(accept), .held(held), .held_target(held_target)
   );

   assign fetch_addr = held ? held_target : pc_link;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RVEC;
      else     pc_q <= fetch_addr;
   end

   assert_reset_load_R1: assert property (@(posedge clk)
      $past(rst) |-> (pc == RVEC && !held));

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(held)) |-> pc == $past(pc) + STEP);

   assert_target_lands_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(accept)) |-> fetch_addr == $past(req_target));

   assert_aligned_R8: assert property (@(posedge clk) disable iff (rst)
      pc[ALIGN_W-1:0] == '0 && fetch_addr[ALIGN_W-1:0] == '0);
endmodule

// File: tb/nextpc_seq_tb.sv
module nextpc_seq_tb;
   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] RVEC       = 32'h20CE88C0;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic        is_jump = 1'b0, is_branch = 1'b0, br_taken = 1'b0;
   logic [31:0] pc, pc_link, fetch_addr;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_pc;
   logic        m_held;
   logic [31:0] m_tgt;

   always #(CLK_PERIOD/2) clk = ~clk;

   nextpc_seq u_dut (
      .clk(clk), .rst(rst), .instr(instr), .is_jump(is_jump),
      .is_branch(is_branch), .br_taken(br_taken),
      .pc(pc), .pc_link(pc_link), .fetch_addr(fetch_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_j(input logic [25:0] f);
      return {6'h02, f};
   endfunction

   function automatic logic [31:0] enc_b(input int off);
      logic [15:0] imm;
      imm = 16'(off);
      return {6'h04, 5'd1, 5'd2, imm};
   endfunction

   // One cycle: drive, check the combinational fetch, clock, check the PC
   task automatic step(input string tag, input logic j, input logic b,
                       input logic t, input logic [31:0] w);
      logic [31:0] nxt, p4;
      int o;
      is_jump = j; is_branch = b; br_taken = t; instr = w;
      p4  = m_pc + 32'd4;
      nxt = m_held ? m_tgt : p4;
      #1;
      chk(m_held ? "R5" : tag, fetch_addr, nxt);
      chk("R8", {30'd0, fetch_addr[1:0]}, 32'd0);
      @(posedge clk);
      if (!m_held && (j || (b && t))) begin
         m_held = 1'b1;
         if (j) m_tgt = {p4[31:28], w[25:0], 2'b00};
         else begin
            o     = int'($signed(w[15:0]));
            m_tgt = p4 + 32'(o * 4);
         end
      end else m_held = 1'b0;
      m_pc = nxt;
      @(negedge clk);
      chk(tag, pc, m_pc);
      chk("R2", pc_link, m_pc + 32'd4);
      is_jump = 0; is_branch = 0; br_taken = 0;
   endtask

   task automatic do_reset;
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_pc = RVEC; m_held = 1'b0; m_tgt = '0;
      chk("R1", pc, RVEC);
      #1;
      chk("R1", fetch_addr, RVEC + 32'd4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      do_reset();

      // R2 sequential flow
      for (int i = 0; i < 8; i++) step("R2", 0, 0, 0, 32'h0);

      // R4 taken branches over a range of offsets, incl. -1 and negatives
      for (int o = -40; o <= 40; o++) begin
         step("R4", 0, 1, 1, enc_b(o));
         step("R5", 0, 0, 0, 32'h0);
         step("R4", 0, 0, 0, 32'h0);
      end
      step("R4", 0, 1, 1, enc_b(-1));
      step("R5", 0, 0, 0, 32'h0);
      step("R4", 0, 0, 0, 32'h0);
      step("R4", 0, 1, 1, enc_b(32767));
      step("R5", 0, 0, 0, 32'h0);
      step("R4", 0, 0, 0, 32'h0);
      step("R4", 0, 1, 1, enc_b(-32768));
      step("R5", 0, 0, 0, 32'h0);
      step("R4", 0, 0, 0, 32'h0);

      // R6 not-taken branches
      for (int o = -8; o <= 8; o++) step("R6", 0, 1, 0, enc_b(o * 5));

      // R3 jumps: walking-one target fields
      for (int k = 0; k < 26; k++) begin
         step("R3", 1, 0, 0, enc_j(26'd1 << k));
         step("R5", 0, 0, 0, 32'h0);
         step("R3", 0, 0, 0, 32'h0);
      end

      // R3 highest address in region 2, then jump out of the region's top
      do_reset();
      step("R3", 1, 0, 0, enc_j(26'h3FFFFFF));
      step("R5", 0, 0, 0, 32'h0);
      chk("R3", pc, 32'h2FFFFFFC);
      step("R3", 1, 0, 0, enc_j(26'h0000010));
      step("R5", 0, 0, 0, 32'h0);
      chk("R3", pc, 32'h30000040);

      // R7 redirect in the delay slot is ignored
      step("R7", 0, 1, 1, enc_b(12));
      step("R7", 1, 0, 0, enc_j(26'h0000ABC));
      step("R7", 0, 0, 0, 32'h0);
      step("R7", 0, 0, 0, 32'h0);
      step("R7", 1, 0, 0, enc_j(26'h0000100));
      step("R7", 0, 1, 1, enc_b(-20));
      step("R7", 0, 0, 0, 32'h0);

      // R9 jump wins over a taken branch
      step("R9", 1, 1, 1, {6'h02, 10'h155, 16'hFFF0});
      step("R5", 0, 0, 0, 32'h0);
      step("R9", 0, 0, 0, 32'h0);

      // R1 reset while a redirect is held
      step("R1", 1, 0, 0, enc_j(26'h0123456));
      do_reset();
      step("R1", 0, 0, 0, 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule